// File: doc/BRIEF.md
# OTP Key Row Reader and Validator

This block pulls a secret key out of a window of one-time-programmable rows. After a start pulse it walks the rows upward from a first row index. It issues one read request per row toward the fuse array and waits for the array to answer. A row whose response carries an ECC-error flag or a failed-programming flag is passed over. Every clean row gives one 32-bit key word, which is streamed out with a valid strobe.

The walk ends when the requested number of words has been gathered, or when the row index moves beyond the last row of the window. Along the way the block keeps a bitwise OR and a bitwise AND of all accepted words. At the end it raises a one-cycle done pulse together with a pass/fail verdict. A key is rejected if it is all zeros, if it is all ones, or if the walk ran beyond the last row. A window that is empty or reversed, or a request for zero words, ends at once with a rejection and issues no reads.

Top module: `otpk_key_reader`

## Requirements
- R1: Rows are requested strictly in ascending order, beginning at `first_row`. `rd_req` stays high with `rd_row` unchanged until `rd_valid` is seen, and then the next row is presented.
- R2: A response with `rd_ecc_err` or `rd_bad_bit` set produces no key word and does not reduce the remaining word count. The walk continues with the next row.
- R3: A clean response produces exactly one `key_valid` pulse in the following cycle, with `key_word` equal to `rd_word`, and reduces the remaining count by one.
- R4: The walk stops once the remaining count reaches zero or the next row index exceeds `last_row`. After that no further row is requested, so the rows visited match a software model exactly.
- R5: The verdict is fail when the AND of the accepted words is all ones, which includes the case where no word was accepted.
- R6: The verdict is fail when the OR of the accepted words is zero.
- R7: The verdict is fail when the row index has moved beyond `last_row` at the stop. This holds even when the last needed word came from `last_row` itself.
- R8: If `first_row` > `last_row` or `num_words` = 0 at start, `done` pulses with `fail` = 1 and no read is issued.
- R9: `done` is a one-cycle pulse. `fail` holds its verdict until the next accepted start. A `start` pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a key walk (taken only when idle) |
| first_row | input | ROW_W | First row of the window |
| last_row | input | ROW_W | Last row of the window |
| num_words | input | CNT_W | Number of key words wanted |
| rd_req | output | 1 | Row read request |
| rd_row | output | ROW_W | Row index being requested |
| rd_valid | input | 1 | Array response for the requested row |
| rd_word | input | KEY_W | Data bits of the row |
| rd_ecc_err | input | 1 | Row reported an ECC error |
| rd_bad_bit | input | 1 | Row reported a failed-programming flag |
| key_valid | output | 1 | Key word strobe |
| key_word | output | KEY_W | Accepted key word |
| done | output | 1 | One-cycle end-of-walk pulse |
| fail | output | 1 | Verdict, 1 = key rejected |

## Verification
The assertions check the cycle-level rules on every clock. These are the held request and the one-row step after each response, the count step on clean rows and the unchanged count on flagged rows, the absence of a key strobe after a flagged row, the one-way drift of the OR and AND accumulators, and the single-cycle done pulse. Only the bench scenarios can show the sequence-wide facts: which rows were visited in total, the exact words streamed, and the verdict for all-zero, all-one and overrun keys. This includes the case where the key finishes on the very last row, as well as reversed or zero-length requests.

// File: rtl/otpk_pkg.sv
package otpk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_FIN   = 2'd2
  } otpk_state_t;

  // A row is usable only when neither integrity flag is raised.
  function automatic logic row_usable(input logic ecc_flag, input logic bad_flag);
    return !(ecc_flag || bad_flag);
  endfunction

endpackage

// File: rtl/otpk_row_screen.sv
module otpk_row_screen #(
  parameter int KEY_W = 32
) (
  input  logic             rsp_valid,
  input  logic             req_active,
  input  logic [KEY_W-1:0] rsp_word,
  input  logic             rsp_ecc,
  input  logic             rsp_bad,
  output logic             rsp_fire,
  output logic             rsp_good,
  output logic             rsp_take,
  output logic [KEY_W-1:0] take_word
);
  import otpk_pkg::*;

  always_comb begin
    rsp_fire  = rsp_valid && req_active;
    rsp_good  = row_usable(rsp_ecc, rsp_bad);
    rsp_take  = rsp_fire && rsp_good;
    take_word = rsp_word;
  end

endmodule

// File: rtl/otpk_accum.sv
module otpk_accum #(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_clear,
  input  logic             acc_en,
  input  logic [KEY_W-1:0] acc_word,
  output logic [KEY_W-1:0] or_acc,
  output logic [KEY_W-1:0] and_acc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      or_acc  <= '0;
      and_acc <= '1;
    end else if (acc_clear) begin
      or_acc  <= '0;
      and_acc <= '1;
    end else if (acc_en) begin
      or_acc  <= or_acc | acc_word;
      and_acc <= and_acc & acc_word;
    end
  end

  AST_OR_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_clear |=> (($past(or_acc) & ~or_acc) == '0)); // R6

  AST_AND_ONLY_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_clear |=> ((~$past(and_acc) & and_acc) == '0)); // R5

endmodule

// File: rtl/otpk_walk_ctrl.sv
module otpk_walk_ctrl #(
  parameter int ROW_W = 10,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] first_row,
  input  logic [ROW_W-1:0] last_row,
  input  logic [CNT_W-1:0] num_words,
  input  logic             rsp_fire,
  input  logic             rsp_take,
  output logic             req_active,
  output logic [ROW_W-1:0] req_row,
  output logic             launch,
  output logic             finish,
  output logic             ran_out
);
  import otpk_pkg::*;

  localparam int RIDX_W = ROW_W + 1;

  otpk_state_t       state_q;
  logic [RIDX_W-1:0] row_q;
  logic [RIDX_W-1:0] row_nxt;
  logic [RIDX_W-1:0] end_ext;
  logic [ROW_W-1:0]  end_q;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  rem_nxt;
  logic              empty_req;
  logic              walk_stop;

  always_comb begin
    end_ext    = {1'b0, end_q};
    row_nxt    = row_q + 1'b1;
    rem_nxt    = rsp_take ? (rem_q - 1'b1) : rem_q;
    walk_stop  = rsp_fire && ((rem_nxt == '0) || (row_nxt > end_ext));
    empty_req  = (first_row > last_row) || (num_words == '0);
    launch     = (state_q == ST_IDLE) && start;
    finish     = (state_q == ST_FIN);
    req_active = (state_q == ST_FETCH);
    req_row    = row_q[ROW_W-1:0];
    ran_out    = row_q > end_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      end_q   <= '0;
      rem_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            row_q   <= {1'b0, first_row};
            end_q   <= last_row;
            rem_q   <= num_words;
            state_q <= empty_req ? ST_FIN : ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (rsp_fire) begin
            row_q <= row_nxt;
            rem_q <= rem_nxt;
            if (walk_stop) state_q <= ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_active |-> (row_q <= end_ext)); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_active && !rsp_fire) |=> (req_active && $stable(row_q))); // R1

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> (row_q == $past(row_q) + 1'b1)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> (rem_q == $past(rem_q) - 1'b1)); // R3

  AST_FLAGGED_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && !rsp_take) |=> (rem_q == $past(rem_q))); // R2

  AST_QUIET_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    walk_stop |=> !req_active); // R4

  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && empty_req) |=> !req_active); // R8

endmodule

// File: rtl/otpk_key_reader.sv
module otpk_key_reader #(
  parameter int ROW_W = 10,
  parameter int CNT_W = 8,
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] first_row,
  input  logic [ROW_W-1:0] last_row,
  input  logic [CNT_W-1:0] num_words,
  output logic             rd_req,
  output logic [ROW_W-1:0] rd_row,
  input  logic             rd_valid,
  input  logic [KEY_W-1:0] rd_word,
  input  logic             rd_ecc_err,
  input  logic             rd_bad_bit,
  output logic             key_valid,
  output logic [KEY_W-1:0] key_word,
  output logic             done,
  output logic             fail
);

  // Rejection rule: all-ones AND, zero OR, or overrun of the window.
  function automatic logic key_rejected(input logic [KEY_W-1:0] or_v,
                                        input logic [KEY_W-1:0] and_v,
                                        input logic             overrun);
    return (&and_v) || (or_v == '0) || overrun;
  endfunction

  logic             rsp_fire;
  logic             rsp_good;
  logic             rsp_take;
  logic [KEY_W-1:0] take_word;
  logic             req_active;
  logic             launch;
  logic             finish;
  logic             ran_out;
  logic [KEY_W-1:0] or_acc;
  logic [KEY_W-1:0] and_acc;

  otpk_row_screen #(.KEY_W(KEY_W)) u_screen (
    .rsp_valid (rd_valid),
    .req_active(req_active),
    .rsp_word  (rd_word),
    .rsp_ecc   (rd_ecc_err),
    .rsp_bad   (rd_bad_bit),
    .rsp_fire  (rsp_fire),
    .rsp_good  (rsp_good),
    .rsp_take  (rsp_take),
    .take_word (take_word)
  );

  otpk_walk_ctrl #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .first_row (first_row),
    .last_row  (last_row),
    .num_words (num_words),
    .rsp_fire  (rsp_fire),
    .rsp_take  (rsp_take),
    .req_active(req_active),
    .req_row   (rd_row),
    .launch    (launch),
    .finish    (finish),
    .ran_out   (ran_out)
  );

  otpk_accum #(.KEY_W(KEY_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_clear(launch),
    .acc_en   (rsp_take),
    .acc_word (take_word),
    .or_acc   (or_acc),
    .and_acc  (and_acc)
  );

  assign rd_req = req_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_valid <= 1'b0;
      key_word  <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      key_valid <= rsp_take;
      if (rsp_take) key_word <= take_word;
      done <= finish;
      if (launch)      fail <= 1'b0;
      else if (finish) fail <= key_rejected(or_acc, and_acc, ran_out);
    end
  end

  AST_FLAGGED_NO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && !rsp_good) |=> !key_valid); // R2

  AST_GOOD_GIVES_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> (key_valid && key_word == $past(rd_word))); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !finish) |=> $stable(fail)); // R9

endmodule

// File: tb/test_otpk_key_reader.sv
module test_otpk_key_reader;
  localparam int ROW_W = 10;
  localparam int CNT_W = 8;
  localparam int KEY_W = 32;
  localparam int NROWS = 1 << ROW_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [ROW_W-1:0] first_row = '0;
  logic [ROW_W-1:0] last_row = '0;
  logic [CNT_W-1:0] num_words = '0;
  logic             rd_req;
  logic [ROW_W-1:0] rd_row;
  logic             rd_valid = 1'b0;
  logic [KEY_W-1:0] rd_word = '0;
  logic             rd_ecc_err = 1'b0;
  logic             rd_bad_bit = 1'b0;
  logic             key_valid;
  logic [KEY_W-1:0] key_word;
  logic             done;
  logic             fail;

  otpk_key_reader #(.ROW_W(ROW_W), .CNT_W(CNT_W), .KEY_W(KEY_W)) i_otpk_key_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .first_row(first_row),
    .last_row(last_row), .num_words(num_words), .rd_req(rd_req), .rd_row(rd_row),
    .rd_valid(rd_valid), .rd_word(rd_word), .rd_ecc_err(rd_ecc_err),
    .rd_bad_bit(rd_bad_bit), .key_valid(key_valid), .key_word(key_word),
    .done(done), .fail(fail)
  );

  always #5 clk = ~clk;

  logic [KEY_W-1:0] mdat [NROWS];
  bit               mecc [NROWS];
  bit               mbad [NROWS];

  int errors = 0;
  int checks = 0;
  int served = 0;
  int exp_row = 0;
  int lat = 0;
  bit mon_on = 1'b0;
  logic [KEY_W-1:0] got_keys[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Fuse array model: answers the current request after 0..3 idle cycles.
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_valid <= 1'b0;
    end else if (rd_req) begin
      if (lat == 0) begin
        chk(int'(rd_row) == exp_row, "R1 row order", rd_row, exp_row);
        exp_row    <= exp_row + 1;
        rd_valid   <= 1'b1;
        rd_word    <= mdat[rd_row];
        rd_ecc_err <= mecc[rd_row];
        rd_bad_bit <= mbad[rd_row];
        served     <= served + 1;
        lat        <= $urandom % 4;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (mon_on && key_valid) got_keys.push_back(key_word);
  end

  task automatic run(input int sr, input int er, input int cnt,
                     input string vtag, input bit poke_busy);
    logic [KEY_W-1:0] exp_keys[$];
    logic [KEY_W-1:0] o_acc;
    logic [KEY_W-1:0] a_acc;
    int row;
    int left;
    bit exp_fail;
    int guard;
    // Bench model of the walk.
    o_acc = '0; a_acc = '1; row = sr; left = cnt;
    while (left > 0 && row <= er) begin
      if (!mecc[row] && !mbad[row]) begin
        exp_keys.push_back(mdat[row]);
        o_acc = o_acc | mdat[row];
        a_acc = a_acc & mdat[row];
        left--;
      end
      row++;
    end
    exp_fail = (a_acc == '1) || (o_acc == '0) || (row > er);

    @(negedge clk);
    got_keys.delete();
    served = 0; exp_row = sr; mon_on = 1'b1;
    first_row = sr[ROW_W-1:0]; last_row = er[ROW_W-1:0]; num_words = cnt[CNT_W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      @(negedge clk);
      first_row = '0; last_row = '0; num_words = 1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 3000, "R9 watchdog done", guard, 0);
    chk(fail == exp_fail, vtag, fail, exp_fail);
    chk(got_keys.size() == exp_keys.size(), "R3 key count", got_keys.size(), exp_keys.size());
    for (int i = 0; i < exp_keys.size() && i < got_keys.size(); i++)
      chk(got_keys[i] == exp_keys[i], "R3 key word", got_keys[i], exp_keys[i]);
    chk(served == row - sr, "R4 rows visited", served, row - sr);
    @(negedge clk);
    chk(!done, "R9 done pulse width", done, 0);
    chk(fail == exp_fail, "R9 verdict held", fail, exp_fail);
    mon_on = 1'b0;
  endtask

  initial begin
    int sr;
    int er;
    void'($urandom(32'd4242));
    for (int i = 0; i < NROWS; i++) begin
      mdat[i] = $urandom;
      mecc[i] = ($urandom % 8) == 0;
      mbad[i] = ($urandom % 10) == 0;
    end
    repeat (3) @(negedge clk);
    chk(!done && !fail && !key_valid && !rd_req, "R9 reset state",
        {done, fail, key_valid, rd_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: clean window
    for (int i = 0; i < 10; i++) begin mecc[i] = 0; mbad[i] = 0; end
    run(0, 9, 4, "R3 clean verdict", 1'b0);
    // R2: flagged rows skipped
    for (int i = 20; i < 30; i++) begin mecc[i] = 0; mbad[i] = 0; end
    mecc[21] = 1; mecc[23] = 1; mbad[24] = 1;
    run(20, 29, 5, "R2 skip verdict", 1'b0);
    // R6: all-zero key
    for (int i = 40; i < 46; i++) begin mecc[i] = 0; mbad[i] = 0; mdat[i] = '0; end
    run(40, 45, 3, "R6 zero key", 1'b0);
    // R5: all-one key
    for (int i = 50; i < 56; i++) begin mecc[i] = 0; mbad[i] = 0; mdat[i] = '1; end
    run(50, 55, 3, "R5 ones key", 1'b0);
    // R7: key finishes on last row -> reject; one spare row -> accept
    for (int i = 60; i < 65; i++) begin mecc[i] = 0; mbad[i] = 0; mdat[i] = 32'h1234_0000 + i; end
    run(60, 63, 4, "R7 finish on last row", 1'b0);
    run(60, 64, 4, "R7 spare row passes", 1'b0);
    run(60, 61, 4, "R7 short window", 1'b0);
    // R8: reversed window and zero words
    run(70, 65, 3, "R8 reversed window", 1'b0);
    run(70, 75, 0, "R8 zero words", 1'b0);
    // R9: start while busy is ignored
    for (int i = 100; i < 160; i++) begin mecc[i] = 0; mbad[i] = 0; end
    run(100, 159, 30, "R9 busy start ignored", 1'b0 | 1'b1);
    // R4 and mixed: random windows
    for (int n = 0; n < 40; n++) begin
      sr = $urandom % 1000;
      er = sr + ($urandom % 24) - 3;
      if (er < 0) er = 0;
      run(sr, er, $urandom % 13, "R4 random verdict", 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule